// File: doc/BRIEF.md
# Display Configuration Register with Pixel-Format Select

This block holds a single 32-bit display configuration word inside a 4 KB system-control register window. Bits 13:8 of the word carry a fixed panel identifier, and the rest of the word is writable in a way that depends on which board variant the block is strapped for. The variant comes in on a static two-bit input. It sets three things: the reset value, which bits a write may change, and whether a write also drives a two-bit pixel-format select.

The select output tells a downstream display controller how to unpack 16-bit pixels. Only the first variant drives it. On that variant every write to the register copies data bits 1:0 onto the output, and the output holds that value until the next such write.

A fourth variant treats the register as absent: it reads as zero and ignores writes. The bus is a plain single-cycle register port. A write is captured on the rising clock edge. Read data is a combinational function of the address and the stored word. Reset is synchronous and active low.

Top module: `disp_cfg_reg`

## Requirements
- R1: Reset on variants 0, 1 and 2 loads the word 0x0000_1F00 (panel ID 0x1F in bits 13:8). On every variant, reset clears the select output to 0.
- R2: On variant 3 the word resets to 0. Reads at the register offset return 0. Writes change neither the word nor the select output.
- R3: On variants 0 and 1, a write at the register offset leaves bits 13:8 unchanged and stores the written data in every other bit.
- R4: On variant 0, a write at the register offset sets the select output to data bits 1:0 from the next clock edge. The output holds between writes.
- R5: On variant 1, writes at the register offset never change the select output, which stays 0.
- R6: On variant 2, a write at the register offset stores data bit 7 only. All other bits keep their current value.
- R7: The register answers at byte offset 0x50 of the window, decoded on address bits 11:2. Writes at any other offset change neither the word nor the select output.
- R8: A read at offset 0x50 returns the stored word in the same cycle and changes no state. Reads at other offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| variant_sel | input | 2 | Static board variant: 0 with select, 1 plain, 2 bit-7 only, 3 absent |
| bus_addr | input | 12 | Byte offset within the register window |
| bus_we | input | 1 | Write strobe for the current address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address and stored word |
| mux_sel | output | 2 | Registered 16-bit pixel-format select |

## Verification
The bench writes all-ones and all-zeros patterns to probe the panel-ID bits. A design that masked the wrong range would let 0x1F be overwritten, or would drop data outside bits 13:8. On variant 2 it writes patterns with and without bit 7 set, to catch an inverted mask that stores everything except bit 7. It also writes at neighbouring offsets and reads back a word that was written earlier. A loose decode would corrupt the word or the select output, and a read with side effects would change the data returned afterwards. On variant 1 and variant 3 it checks that the select output stays 0, which catches a design that drives it on every variant. On variant 3 it checks that nothing at all reaches the read path.

// File: rtl/dcfg_pkg.sv
package dcfg_pkg;

  localparam int CFG_W    = 32;
  localparam int ID_LSB   = 8;
  localparam int ID_W     = 6;
  localparam int ID_VALUE = 6'h1f;
  localparam int OPEN_BIT = 7;
  localparam int SEL_W    = 2;

  typedef enum logic [1:0] {
    BRD_MUXED  = 2'd0,
    BRD_PLAIN  = 2'd1,
    BRD_NARROW = 2'd2,
    BRD_ABSENT = 2'd3
  } board_e;

  // Positions of the fixed panel identifier.
  function automatic logic [CFG_W-1:0] id_field_mask();
    logic [CFG_W-1:0] m;
    m = '0;
    for (int i = ID_LSB; i < ID_LSB + ID_W; i++) m[i] = 1'b1;
    return m;
  endfunction

  // Bits a bus write may change for a given variant.
  function automatic logic [CFG_W-1:0] write_mask(board_e b);
    logic [CFG_W-1:0] m;
    case (b)
      BRD_MUXED, BRD_PLAIN: m = ~id_field_mask();
      BRD_NARROW: begin
        m = '0;
        m[OPEN_BIT] = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic [CFG_W-1:0] reset_word(board_e b);
    logic [CFG_W-1:0] w;
    w = '0;
    if (b != BRD_ABSENT) w[ID_LSB +: ID_W] = ID_W'(ID_VALUE);
    return w;
  endfunction

  function automatic logic drives_select(board_e b);
    return b == BRD_MUXED;
  endfunction

endpackage

// File: rtl/dcfg_addr_dec.sv
module dcfg_addr_dec #(
  parameter int ADDR_W     = 12,
  parameter int REG_OFFSET = 'h50
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] OFFS = ADDR_W'(REG_OFFSET);

  // Word-aligned decode: the two byte-lane bits are ignored.
  assign hit = (addr[ADDR_W-1:2] == OFFS[ADDR_W-1:2]);
endmodule

// File: rtl/dcfg_word_reg.sv
module dcfg_word_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rst_word,
  input  logic         wr_en,
  input  logic [W-1:0] wmask,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                 bit_q <= rst_word[i];
      else if (wr_en && wmask[i]) bit_q <= wdata[i];
    end
    assign q[i] = bit_q;
  end
endmodule

// File: rtl/dcfg_sel_drv.sv
module dcfg_sel_drv #(
  parameter int SW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [SW-1:0] value,
  output logic [SW-1:0] sel
);
  always_ff @(posedge clk) begin
    if (!rst_n)    sel <= '0;
    else if (load) sel <= value;
  end
endmodule

// File: rtl/disp_cfg_reg.sv
module disp_cfg_reg
  import dcfg_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int REG_OFFSET = 'h50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        variant_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [CFG_W-1:0]  bus_wdata,
  output logic [CFG_W-1:0]  bus_rdata,
  output logic [SEL_W-1:0]  mux_sel
);
  board_e           board;
  logic             addr_hit;
  logic             wr_hit;
  logic             sel_load;
  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cur_mask;
  logic [CFG_W-1:0] cur_rst;

  assign board    = board_e'(variant_sel);
  assign cur_mask = write_mask(board);
  assign cur_rst  = reset_word(board);

  dcfg_addr_dec #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_dec (
    .addr (bus_addr),
    .hit  (addr_hit)
  );

  assign wr_hit   = bus_we && addr_hit;
  assign sel_load = wr_hit && drives_select(board);

  dcfg_word_reg #(.W(CFG_W)) u_word (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_word (cur_rst),
    .wr_en    (wr_hit),
    .wmask    (cur_mask),
    .wdata    (bus_wdata),
    .q        (cfg_q)
  );

  dcfg_sel_drv #(.SW(SEL_W)) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sel_load),
    .value (bus_wdata[SEL_W-1:0]),
    .sel   (mux_sel)
  );

  assign bus_rdata = (addr_hit && board != BRD_ABSENT) ? cfg_q : '0;
endmodule

// File: rtl/dcfg_checker.sv
module dcfg_checker
  import dcfg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       variant_sel,
  input logic             bus_we,
  input logic [CFG_W-1:0] bus_wdata,
  input logic [CFG_W-1:0] bus_rdata,
  input logic [SEL_W-1:0] mux_sel,
  input logic             wr_hit,
  input logic [CFG_W-1:0] cfg_q
);
  assert_id_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && variant_sel inside {2'd0, 2'd1}) |-> $stable(cfg_q[13:8]));

  assert_sel_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_hit) && variant_sel == 2'd0)
      |-> mux_sel == $past(bus_wdata[1:0]));

  assert_sel_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    variant_sel != 2'd0 |-> mux_sel == 2'b00);

  assert_absent_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    variant_sel == 2'd3 |-> (bus_rdata == '0 && cfg_q == '0));

  assert_narrow_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && variant_sel == 2'd2)
      |-> ($stable(cfg_q[31:8]) && $stable(cfg_q[6:0])));

  assert_miss_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_hit)) |-> ($stable(cfg_q) && $stable(mux_sel)));
endmodule

bind disp_cfg_reg dcfg_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .variant_sel (variant_sel),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .mux_sel     (mux_sel),
  .wr_hit      (wr_hit),
  .cfg_q       (cfg_q)
);

// File: tb/tb_disp_cfg_reg.sv
module tb_disp_cfg_reg;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] REG_AT = 12'h050;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  variant_sel = 2'd0;
  logic [11:0] bus_addr = 12'h0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [1:0]  mux_sel;

  int checks = 0;
  int errors = 0;

  disp_cfg_reg dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .variant_sel (variant_sel),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .mux_sel     (mux_sel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic do_reset(logic [1:0] v);
    @(negedge clk);
    rst_n = 1'b0;
    variant_sel = v;
    bus_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic do_read(logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // Expected word on variants 0 and 1: the ID bits always read 0x1F.
  function automatic logic [31:0] wide_expect(logic [31:0] d);
    return {d[31:14], 6'b011111, d[7:0]};
  endfunction

  task automatic t_variant0;
    logic [31:0] r;
    do_reset(2'd0);
    do_read(REG_AT, r);
    check("R1 reset word v0", r, 32'h0000_1F00);
    check("R1 reset select", {30'h0, mux_sel}, 32'h0);
    do_write(REG_AT, 32'h0000_0000);
    do_read(REG_AT, r);
    check("R3 zeros keep id", r, 32'h0000_1F00);
    do_write(REG_AT, 32'hA5A5_C0C3);
    do_read(REG_AT, r);
    check("R3 pattern", r, wide_expect(32'hA5A5_C0C3));
    check("R4 select from data", {30'h0, mux_sel}, 32'h3);
    do_write(REG_AT, 32'h0000_0001);
    check("R4 select update", {30'h0, mux_sel}, 32'h1);
    repeat (3) @(negedge clk);
    check("R4 select holds", {30'h0, mux_sel}, 32'h1);
    do_write(12'h054, 32'hFFFF_FFFE);
    do_write(12'h010, 32'h1234_5672);
    do_read(REG_AT, r);
    check("R7 miss keeps word", r, wide_expect(32'h0000_0001));
    check("R7 miss keeps select", {30'h0, mux_sel}, 32'h1);
    do_read(12'h054, r);
    check("R8 other offset reads 0", r, 32'h0);
    do_read(REG_AT, r);
    do_read(REG_AT, r);
    check("R8 repeat read no side effect", r, wide_expect(32'h0000_0001));
  endtask

  task automatic t_variant1;
    logic [31:0] r;
    do_reset(2'd1);
    do_read(REG_AT, r);
    check("R1 reset word v1", r, 32'h0000_1F00);
    do_write(REG_AT, 32'h5A5A_2A5E);
    do_read(REG_AT, r);
    check("R3 v1 pattern", r, wide_expect(32'h5A5A_2A5E));
    check("R5 v1 select stays 0", {30'h0, mux_sel}, 32'h0);
    do_write(REG_AT, 32'hFFFF_FFFF);
    check("R5 v1 select after ones", {30'h0, mux_sel}, 32'h0);
  endtask

  task automatic t_variant2;
    logic [31:0] r;
    do_reset(2'd2);
    do_read(REG_AT, r);
    check("R1 reset word v2", r, 32'h0000_1F00);
    do_write(REG_AT, 32'hFFFF_FFFF);
    do_read(REG_AT, r);
    check("R6 only bit7 set", r, 32'h0000_1F80);
    do_write(REG_AT, 32'hFFFF_FF7F);
    do_read(REG_AT, r);
    check("R6 bit7 cleared", r, 32'h0000_1F00);
    check("R5 v2 select stays 0", {30'h0, mux_sel}, 32'h0);
  endtask

  task automatic t_variant3;
    logic [31:0] r;
    do_reset(2'd3);
    do_read(REG_AT, r);
    check("R2 reset reads 0", r, 32'h0);
    do_write(REG_AT, 32'hFFFF_FFFF);
    do_read(REG_AT, r);
    check("R2 write ignored", r, 32'h0);
    check("R2 select stays 0", {30'h0, mux_sel}, 32'h0);
  endtask

  task automatic t_reset_again;
    logic [31:0] r;
    do_reset(2'd0);
    do_write(REG_AT, 32'h0000_0002);
    check("R4 select before reset", {30'h0, mux_sel}, 32'h2);
    do_reset(2'd0);
    do_read(REG_AT, r);
    check("R1 reset restores word", r, 32'h0000_1F00);
    check("R1 reset clears select", {30'h0, mux_sel}, 32'h0);
  endtask

  initial begin
    fork
      begin
        t_variant0();
        t_variant1();
        t_variant2();
        t_variant3();
        t_reset_again();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule